// File: doc/BRIEF.md
# Phase-Gated Pipeline Delay Line

This block delays a data word through a fixed chain of registers, as used for lining up paths in a multi-rate datapath. The chain does not shift on every clock. A repeating cycle of `NUM_PHASES` phases runs inside the block. A mask given at build time marks which phases move the chain, so the chain only shifts on the chosen slots of a slower sample rate sharing the fast clock.

The leftmost (most significant) mask bit belongs to phase 1, which is the first phase after reset or clear. The block has two optional inputs, each turned on by a parameter. The first is a clock enable that freezes the whole block. The second is a synchronous clear that loads a chosen reset constant into every stage and restarts the phase cycle. The asynchronous active-low reset is released in step with the clock, and it loads the same constant.

Top module: `phase_gated_delay`

## Requirements
- R1: After reset, every stage holds `CLEAR_VAL`, so `dout` equals `CLEAR_VAL`, and the phase cycle stands at phase 1.
- R2: The phase moves 1, 2, …, `NUM_PHASES` and back to 1, one step per enabled cycle. The cycle continues where it stopped after the clock enable was low.
- R3: Phase k moves the chain when bit `NUM_PHASES-k` of `PHASE_MASK` is 1, so the MSB belongs to phase 1. With the default `4'b0100`, only the second phase of every four moves the chain.
- R4: On a moving cycle, `din` enters stage 1 and each later stage takes the value of the stage before it. `dout` is the last stage, so a word reaches `dout` after `STAGES` moving cycles.
- R5: On an enabled cycle whose phase bit is 0, every stage keeps its value.
- R6: With `USE_CE`=1 and `ce`=0 (and no clear), neither the stages nor the phase change, whatever `din` does.
- R7: With `USE_CLR`=1, `clr`=1 loads `CLEAR_VAL` into every stage and returns the phase to 1 on the next edge. Clear takes priority over `ce`, and it acts even when `ce`=0.
- R8: With `USE_CE`=0 the `ce` input has no effect. With `USE_CLR`=0 the `clr` input has no effect.
- R9: With two phases and mask `2'b01`, the chain moves on every other enabled cycle, starting with the second cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce | input | 1 | Clock enable; used only when `USE_CE`=1 |
| clr | input | 1 | Synchronous clear; used only when `USE_CLR`=1 |
| din | input | DATA_W | Data word entering stage 1 |
| dout | output | DATA_W | Last stage of the chain |

## Verification
The hardest case to reach from the ports is a clock-enable pause that starts in the middle of the phase cycle. After the pause, the next moving cycle must fall on the phase where the cycle stopped, not on a restarted count. A clear asserted while `ce` is low is hard to reach for the same reason. The stimulus pauses `ce` at uneven offsets, using patterns that are not multiples of the phase count. It also places clears both with `ce` high and with `ce` low. It runs a second instance with two phases, no enable and no clear on the same wires. The bench model is a word queue indexed by the mask written as a string.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  // width of an index over n items, never below one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pdl_rst_sync.sv
module pdl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_s_n <= meta_q;
    end
  end
endmodule

// File: rtl/pdl_phase_ctr.sv
module pdl_phase_ctr #(
  parameter int unsigned NUM_PHASES = 4,
  parameter logic [NUM_PHASES-1:0] PHASE_MASK = 4'b0100,
  localparam int unsigned PH_W = pdl_pkg::idx_w(NUM_PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce,
  input  logic            clr,
  output logic            adv,
  output logic [PH_W-1:0] ph_q
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

  logic [PH_W-1:0] ph_d;

  always_comb begin
    ph_d = ph_q;
    if (clr) begin
      ph_d = '0;
    end else if (ce) begin
      ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end

  // leftmost mask bit is phase 1
  assign adv = ce & ~clr & PHASE_MASK[LAST - ph_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end
endmodule

// File: rtl/pdl_stage_chain.sv
module pdl_stage_chain #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAGES = 3,
  parameter logic [DATA_W-1:0] CLEAR_VAL = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     clr,
  input  logic [DATA_W-1:0]        din,
  output logic [DATA_W-1:0]        dout,
  output logic [STAGES*DATA_W-1:0] stg_flat
);
  logic [DATA_W-1:0] stg_q [STAGES];
  logic [DATA_W-1:0] stg_d [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    logic [DATA_W-1:0] src;
    if (gi == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = stg_q[gi-1];
    end

    always_comb begin
      if (clr) begin
        stg_d[gi] = CLEAR_VAL;
      end else if (adv) begin
        stg_d[gi] = src;
      end else begin
        stg_d[gi] = stg_q[gi];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[gi] <= CLEAR_VAL;
      end else begin
        stg_q[gi] <= stg_d[gi];
      end
    end

    assign stg_flat[gi*DATA_W +: DATA_W] = stg_q[gi];
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/phase_gated_delay.sv
module phase_gated_delay #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STAGES     = 3,
  parameter int unsigned NUM_PHASES = 4,
  parameter logic [NUM_PHASES-1:0] PHASE_MASK = 4'b0100,
  parameter logic [DATA_W-1:0]     CLEAR_VAL  = 8'hA5,
  parameter bit USE_CE  = 1'b1,
  parameter bit USE_CLR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              clr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned PH_W = pdl_pkg::idx_w(NUM_PHASES);

  logic                     rst_s_n;
  logic                     ce_eff;
  logic                     clr_eff;
  logic                     adv;
  logic [PH_W-1:0]          ph_q;
  logic [STAGES*DATA_W-1:0] stg_flat;

  assign ce_eff  = USE_CE  ? ce  : 1'b1;
  assign clr_eff = USE_CLR ? clr : 1'b0;

  pdl_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pdl_phase_ctr #(
    .NUM_PHASES (NUM_PHASES),
    .PHASE_MASK (PHASE_MASK)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_s_n),
    .ce    (ce_eff),
    .clr   (clr_eff),
    .adv   (adv),
    .ph_q  (ph_q)
  );

  pdl_stage_chain #(
    .DATA_W    (DATA_W),
    .STAGES    (STAGES),
    .CLEAR_VAL (CLEAR_VAL)
  ) u_chain (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .adv      (adv),
    .clr      (clr_eff),
    .din      (din),
    .dout     (dout),
    .stg_flat (stg_flat)
  );
endmodule

// File: rtl/pdl_checker.sv
module pdl_checker #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STAGES     = 3,
  parameter int unsigned NUM_PHASES = 4,
  parameter logic [DATA_W-1:0] CLEAR_VAL = '0,
  localparam int unsigned PH_W = pdl_pkg::idx_w(NUM_PHASES)
) (
  input logic                     clk,
  input logic                     rst_s_n,
  input logic                     ce_eff,
  input logic                     clr_eff,
  input logic                     adv,
  input logic [PH_W-1:0]          ph_q,
  input logic [DATA_W-1:0]        din,
  input logic [DATA_W-1:0]        dout,
  input logic [STAGES*DATA_W-1:0] stg_flat
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ce_eff && !clr_eff && ph_q == LAST) |=> ph_q == '0);

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ce_eff && !clr_eff && ph_q != LAST) |=> ph_q == $past(ph_q) + 1'b1);

  assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    adv |=> stg_flat[DATA_W-1:0] == $past(din));

  assert_skip_hold_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ce_eff && !clr_eff && !adv) |=> $stable(stg_flat));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ce_eff && !clr_eff) |=> ($stable(dout) && $stable(ph_q)));

  assert_clear_load_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr_eff |=> (dout == CLEAR_VAL && ph_q == '0));
endmodule

bind phase_gated_delay pdl_checker #(
  .DATA_W     (DATA_W),
  .STAGES     (STAGES),
  .NUM_PHASES (NUM_PHASES),
  .CLEAR_VAL  (CLEAR_VAL)
) u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .ce_eff   (ce_eff),
  .clr_eff  (clr_eff),
  .adv      (adv),
  .ph_q     (ph_q),
  .din      (din),
  .dout     (dout),
  .stg_flat (stg_flat)
);

// File: tb/phase_gated_delay_test.sv
module phase_gated_delay_test;
  localparam int CLK_PERIOD = 10;
  localparam int A_STAGES = 3;
  localparam int B_STAGES = 2;
  localparam string A_MASK = "0100";
  localparam string B_MASK = "01";
  localparam logic [7:0] A_CLR = 8'hA5;
  localparam logic [7:0] B_CLR = 8'h00;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout_a;
  logic [7:0] dout_b;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] qa [A_STAGES];
  logic [7:0] qb [B_STAGES];
  int pa = 0;
  int pb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_gated_delay #(
    .DATA_W(8), .STAGES(A_STAGES), .NUM_PHASES(4), .PHASE_MASK(4'b0100),
    .CLEAR_VAL(A_CLR), .USE_CE(1'b1), .USE_CLR(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .din(din), .dout(dout_a)
  );

  phase_gated_delay #(
    .DATA_W(8), .STAGES(B_STAGES), .NUM_PHASES(2), .PHASE_MASK(2'b01),
    .CLEAR_VAL(B_CLR), .USE_CE(1'b0), .USE_CLR(1'b0)
  ) uut_b (
    .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .din(din), .dout(dout_b)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < A_STAGES; i++) qa[i] = A_CLR;
    for (int i = 0; i < B_STAGES; i++) qb[i] = B_CLR;
    pa = 0;
    pb = 0;
  endtask

  // drive at negedge, model the next posedge, check at the following negedge
  task automatic step(input string tag_a, input logic [7:0] d, input logic c, input logic k);
    string tag_b;
    din = d; ce = c; clr = k;
    @(posedge clk);
    if (k) begin
      for (int i = 0; i < A_STAGES; i++) qa[i] = A_CLR;
      pa = 0;
    end else if (c) begin
      if (A_MASK[pa] == "1") begin
        for (int i = A_STAGES-1; i > 0; i--) qa[i] = qa[i-1];
        qa[0] = d;
      end
      pa = (pa + 1) % A_MASK.len();
    end
    if (B_MASK[pb] == "1") begin
      for (int i = B_STAGES-1; i > 0; i--) qb[i] = qb[i-1];
      qb[0] = d;
    end
    pb = (pb + 1) % B_MASK.len();
    @(negedge clk);
    tag_b = (!c || k) ? "R8" : "R9";
    check(tag_a, dout_a, qa[A_STAGES-1]);
    check(tag_b, dout_b, qb[B_STAGES-1]);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", dout_a, A_CLR);
    check("R1", dout_b, B_CLR);

    // R3: phase 1 holds, phase 2 moves; R4 through the full chain
    step("R3", 8'h11, 1'b1, 1'b0);
    step("R3", 8'h22, 1'b1, 1'b0);
    step("R5", 8'h33, 1'b1, 1'b0);
    step("R5", 8'h44, 1'b1, 1'b0);
    for (int i = 0; i < 24; i++) step("R4", 8'(i*37 + 5), 1'b1, 1'b0);

    // R6: pause mid-cycle with moving data
    step("R4", 8'h5A, 1'b1, 1'b0);
    for (int i = 0; i < 7; i++) step("R6", 8'(i*19 + 1), 1'b0, 1'b0);
    for (int i = 0; i < 9; i++) step("R2", 8'(i*11 + 9), 1'b1, 1'b0);

    // R7: clear with and without enable, then phase restart
    step("R7", 8'hEE, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step("R7", 8'(i*23 + 2), 1'b1, 1'b0);
    step("R4", 8'h77, 1'b1, 1'b0);
    step("R7", 8'hCC, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) step("R7", 8'(i*29 + 3), 1'b1, 1'b0);

    // uneven enable pattern sweep
    for (int i = 0; i < 60; i++)
      step("R5", 8'(i*13 + 7), (i % 3) != 0, (i == 31));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule